// File: doc/BRIEF.md
# USB Descriptor Fetch Unit

This block answers standard Get Descriptor requests for a full-speed USB device. The control-endpoint logic hands it a decoded request: the descriptor type, the descriptor index and the length the host asked for. The block finds where the matching descriptor starts in one packed, read-only descriptor memory and how long it is. It then sends the bytes one per beat to the transmit side over a valid/ready handshake and flags the final byte. A request it cannot serve produces a one-cycle error pulse so that the control logic can answer with a STALL.

The memory holds three regions back to back. The first is the 18-byte device descriptor. The second is the configuration set, in which the configuration, interface and endpoint descriptors sit in one contiguous run. The third is the string region. In that region the 4-byte language descriptor comes first and the Unicode strings follow it with no gaps. A per-index table gives the start offset of each string, so the block never scans the region.

The control sequence has five named states. S_IDLE accepts a request (S_IDLE to S_CHECK when `req_valid` is high). S_CHECK judges the registered request and goes to S_FAIL on an error, to S_DONE when the byte count is zero, or otherwise to S_SEND. S_SEND presents bytes and goes to S_DONE when the last byte is taken. S_DONE and S_FAIL each last one cycle and then go back to S_IDLE.

Top module: `desc_fetch_unit`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, and `tx_valid`, `tx_last`, `done` and `req_err` are all 0.
- R2: Type 1 (device) is served from address 0 with a stored length of 18, and the descriptor index is ignored. Byte 0 is 18 and byte 1 is 1. Every memory byte that no requirement defines holds its absolute address XOR 0x5A, in the low 8 bits.
- R3: Type 2 (configuration) with index 0 is served from address 18 as one 32-byte run (default of two endpoints). The relative bytes are: 0 = 9, 1 = 2, 2 = total length low byte (32), 3 = total length high byte (0), 9 = 9, 10 = 4, 18 and 25 = 7, 19 and 26 = 5.
- R4: Type 3 (string) with index 0 returns the 4 bytes 0x04, 0x03, 0x09, 0x04, starting at address 50.
- R5: String index k, for 1 ≤ k ≤ 3, returns a descriptor of length 2k+8. It is located at string-region offset 4 plus the lengths of strings 1 to k−1. Its bytes are: the length, then 3, then alternating 0x40+k and 0x00.
- R6: The number of bytes sent is the smaller of the requested length and the stored length.
- R7: Some requests raise `req_err` for exactly one cycle, send no bytes and give no `done`: a type other than 1, 2 or 3, a configuration index other than 0, a string index of 5 or more (beyond the table), and string index 4 (a table entry marked invalid).
- R8: A requested length of 0 on a valid request sends no bytes and pulses `done` once.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_last` hold. `tx_last` is high only on the final byte of the truncated length.
- R10: `req_ready` is low from the cycle after acceptance until the request completes. `done` pulses in the cycle after the last byte is taken.
- R11: The read address presented while bytes are sent always lies inside the memory (below 90).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_type | input | 8 | Descriptor type (1 device, 2 configuration, 3 string) |
| req_index | input | 8 | Descriptor index |
| req_len | input | 16 | Host-requested length in bytes |
| tx_data | output | 8 | Descriptor byte |
| tx_valid | output | 1 | Byte valid |
| tx_ready | input | 1 | Transmit side takes the byte |
| tx_last | output | 1 | Final byte of the response |
| done | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | One-cycle request-error pulse |

## Verification
The bench goes after the truncation boundary, the string table and the handshake, because each of them fails in a distinct way.

- **Truncation boundary.** It uses lengths of 0, 1, exactly the stored length and beyond it. A design that compares with the wrong bound sends one byte too many or too few, or misplaces `tx_last`. A design that mishandles zero sends a stray byte or never completes.
- **String table.** It visits index 0, every populated index, the invalid entry and indices beyond the table. A design with a wrong offset sum returns the bytes of a neighbouring string. A design that ignores the valid mark streams garbage instead of erroring.
- **Handshake.** Random back-pressure exposes any design that advances its address without `tx_ready`, which shows up as skipped or repeated bytes.
- **Configuration index.** A non-zero configuration index must error.
- **Device index.** A non-zero device index must not error, which catches an over-eager index check.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;

    localparam logic [7:0] DT_DEVICE = 8'd1;
    localparam logic [7:0] DT_CONFIG = 8'd2;
    localparam logic [7:0] DT_STRING = 8'd3;

    localparam int DEV_BYTES  = 18;
    localparam int LANG_BYTES = 4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_SEND,
        S_DONE,
        S_FAIL
    } fetch_state_t;

    // configuration + one interface + endpoints
    function automatic int cfg_bytes(input int n_ep);
        return 9 + 9 + 7 * n_ep;
    endfunction

    // string k carries k+3 UTF-16 characters
    function automatic int str_bytes(input int k);
        return 2 * k + 8;
    endfunction

    // offset of string k (k >= 1) within the string region
    function automatic int str_rel_off(input int k);
        int o;
        o = LANG_BYTES;
        for (int j = 1; j < k; j++) o += str_bytes(j);
        return o;
    endfunction

    function automatic int mem_bytes(input int n_ep, input int n_str);
        return DEV_BYTES + cfg_bytes(n_ep) + str_rel_off(n_str + 1);
    endfunction

    function automatic logic [7:0] rom_byte(input int a, input int n_ep, input int n_str);
        int         cb;
        int         sb;
        int         off;
        int         ro;
        int         rel;
        logic [7:0] b;
        cb  = DEV_BYTES;
        sb  = cb + cfg_bytes(n_ep);
        b   = 8'(a) ^ 8'h5A;
        if (a < cb) begin
            if (a == 0) b = 8'(DEV_BYTES);
            else if (a == 1) b = DT_DEVICE;
        end else if (a < sb) begin
            off = a - cb;
            if (off == 0) b = 8'd9;
            else if (off == 1) b = DT_CONFIG;
            else if (off == 2) b = 8'(cfg_bytes(n_ep));
            else if (off == 3) b = 8'(cfg_bytes(n_ep) >> 8);
            else if (off == 9) b = 8'd9;
            else if (off == 10) b = 8'd4;
            for (int e = 0; e < n_ep; e++) begin
                if (off == 18 + 7 * e) b = 8'd7;
                if (off == 19 + 7 * e) b = 8'd5;
            end
        end else begin
            off = a - sb;
            if (off == 0) b = 8'h04;
            else if (off == 1) b = DT_STRING;
            else if (off == 2) b = 8'h09;
            else if (off == 3) b = 8'h04;
            for (int k = 1; k <= n_str; k++) begin
                ro = str_rel_off(k);
                if (off >= ro && off < ro + str_bytes(k)) begin
                    rel = off - ro;
                    if (rel == 0) b = 8'(str_bytes(k));
                    else if (rel == 1) b = DT_STRING;
                    else if (rel % 2 == 1) b = 8'h00;
                    else b = 8'(8'h40 + k);
                end
            end
        end
        return b;
    endfunction

endpackage

// File: rtl/desc_rom.sv
module desc_rom
    import desc_fetch_pkg::*;
#(
    parameter int N_EP  = 2,
    parameter int N_STR = 3,
    parameter int AW    = 7
) (
    input  logic [AW-1:0] addr,
    output logic [7:0]    data
);

    localparam int MEM_BYTES = mem_bytes(N_EP, N_STR);

    logic [7:0] mem [MEM_BYTES];

    for (genvar i = 0; i < MEM_BYTES; i++) begin : g_byte
        localparam logic [7:0] BYTE_VAL = rom_byte(i, N_EP, N_STR);
        assign mem[i] = BYTE_VAL;
    end

    always_comb begin
        data = 8'h00;
        if (int'(addr) < MEM_BYTES) data = mem[addr];
    end

endmodule

// File: rtl/desc_str_table.sv
module desc_str_table
    import desc_fetch_pkg::*;
#(
    parameter int N_STR     = 3,
    parameter int STR_SLOTS = 5,
    parameter int STR_BASE  = 50,
    parameter int AW        = 7,
    parameter int LW        = 16
) (
    input  logic [7:0]    idx,
    output logic [AW-1:0] off,
    output logic [LW-1:0] len,
    output logic          hit
);

    logic [AW-1:0] slot_off [STR_SLOTS];
    logic [LW-1:0] slot_len [STR_SLOTS];
    logic          slot_ok  [STR_SLOTS];

    for (genvar s = 0; s < STR_SLOTS; s++) begin : g_slot
        localparam int SOFF = (s == 0) ? STR_BASE :
                              ((s <= N_STR) ? STR_BASE + str_rel_off(s) : 0);
        localparam int SLEN = (s == 0) ? LANG_BYTES :
                              ((s <= N_STR) ? str_bytes(s) : 0);
        assign slot_off[s] = AW'(SOFF);
        assign slot_len[s] = LW'(SLEN);
        assign slot_ok[s]  = (s <= N_STR);
    end

    always_comb begin
        off = '0;
        len = '0;
        hit = 1'b0;
        for (int s = 0; s < STR_SLOTS; s++) begin
            if (idx == 8'(s) && slot_ok[s]) begin
                off = slot_off[s];
                len = slot_len[s];
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/desc_lookup.sv
module desc_lookup
    import desc_fetch_pkg::*;
#(
    parameter int N_EP      = 2,
    parameter int N_STR     = 3,
    parameter int STR_SLOTS = 5,
    parameter int AW        = 7,
    parameter int LW        = 16
) (
    input  logic [7:0]    d_type,
    input  logic [7:0]    d_index,
    input  logic [LW-1:0] d_len,
    output logic [AW-1:0] start,
    output logic [LW-1:0] count,
    output logic          err
);

    localparam int CFG_BASE = DEV_BYTES;
    localparam int CFG_LEN  = cfg_bytes(N_EP);
    localparam int STR_BASE = CFG_BASE + CFG_LEN;

    logic [AW-1:0] s_off;
    logic [LW-1:0] s_len;
    logic          s_hit;
    logic [LW-1:0] stored;

    desc_str_table #(
        .N_STR    (N_STR),
        .STR_SLOTS(STR_SLOTS),
        .STR_BASE (STR_BASE),
        .AW       (AW),
        .LW       (LW)
    ) u_str_table (
        .idx(d_index),
        .off(s_off),
        .len(s_len),
        .hit(s_hit)
    );

    always_comb begin
        start  = '0;
        stored = '0;
        err    = 1'b0;
        case (d_type)
            DT_DEVICE: begin
                start  = '0;
                stored = LW'(DEV_BYTES);
            end
            DT_CONFIG: begin
                if (d_index != 8'd0) begin
                    err = 1'b1;
                end else begin
                    start  = AW'(CFG_BASE);
                    stored = LW'(CFG_LEN);
                end
            end
            DT_STRING: begin
                if (!s_hit) begin
                    err = 1'b1;
                end else begin
                    start  = s_off;
                    stored = s_len;
                end
            end
            default: err = 1'b1;
        endcase
        count = (d_len < stored) ? d_len : stored;
    end

endmodule

// File: rtl/desc_streamer.sv
module desc_streamer
    import desc_fetch_pkg::*;
#(
    parameter int AW = 7,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [7:0]    req_type,
    input  logic [7:0]    req_index,
    input  logic [LW-1:0] req_len,
    output logic [7:0]    lk_type,
    output logic [7:0]    lk_index,
    output logic [LW-1:0] lk_len,
    input  logic [AW-1:0] lk_start,
    input  logic [LW-1:0] lk_count,
    input  logic          lk_err,
    output logic [AW-1:0] rd_addr,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          tx_last,
    output logic          done,
    output logic          req_err
);

    fetch_state_t  state;
    fetch_state_t  nxt;
    logic [LW-1:0] remaining;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_valid) nxt = S_CHECK;
            S_CHECK: begin
                if (lk_err)                nxt = S_FAIL;
                else if (lk_count == '0)   nxt = S_DONE;
                else                       nxt = S_SEND;
            end
            S_SEND:  if (tx_ready && remaining == LW'(1)) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            S_FAIL:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_type   <= '0;
            lk_index  <= '0;
            lk_len    <= '0;
            rd_addr   <= '0;
            remaining <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                lk_type  <= req_type;
                lk_index <= req_index;
                lk_len   <= req_len;
            end
            if (state == S_CHECK) begin
                rd_addr   <= lk_start;
                remaining <= lk_count;
            end
            if (state == S_SEND && tx_ready) begin
                remaining <= remaining - LW'(1);
                if (remaining != LW'(1)) rd_addr <= rd_addr + AW'(1);
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        tx_valid  = 1'b0;
        tx_last   = 1'b0;
        done      = 1'b0;
        req_err   = 1'b0;
        unique case (state)
            S_IDLE:  req_ready = 1'b1;
            S_CHECK: ;
            S_SEND: begin
                tx_valid = 1'b1;
                tx_last  = (remaining == LW'(1));
            end
            S_DONE:  done    = 1'b1;
            S_FAIL:  req_err = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/desc_fetch_unit.sv
module desc_fetch_unit
    import desc_fetch_pkg::*;
#(
    parameter int N_EP      = 2,
    parameter int N_STR     = 3,
    parameter int STR_SLOTS = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [7:0]  req_type,
    input  logic [7:0]  req_index,
    input  logic [15:0] req_len,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic        tx_last,
    output logic        done,
    output logic        req_err
);

    localparam int MEM_BYTES = mem_bytes(N_EP, N_STR);
    localparam int AW        = $clog2(MEM_BYTES);
    localparam int LW        = 16;

    logic [7:0]    lk_type;
    logic [7:0]    lk_index;
    logic [LW-1:0] lk_len;
    logic [AW-1:0] lk_start;
    logic [LW-1:0] lk_count;
    logic          lk_err;
    logic [AW-1:0] rd_addr;

    desc_streamer #(.AW(AW), .LW(LW)) u_streamer (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_type (req_type),
        .req_index(req_index),
        .req_len  (req_len),
        .lk_type  (lk_type),
        .lk_index (lk_index),
        .lk_len   (lk_len),
        .lk_start (lk_start),
        .lk_count (lk_count),
        .lk_err   (lk_err),
        .rd_addr  (rd_addr),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tx_last  (tx_last),
        .done     (done),
        .req_err  (req_err)
    );

    desc_lookup #(
        .N_EP     (N_EP),
        .N_STR    (N_STR),
        .STR_SLOTS(STR_SLOTS),
        .AW       (AW),
        .LW       (LW)
    ) u_lookup (
        .d_type (lk_type),
        .d_index(lk_index),
        .d_len  (lk_len),
        .start  (lk_start),
        .count  (lk_count),
        .err    (lk_err)
    );

    desc_rom #(.N_EP(N_EP), .N_STR(N_STR), .AW(AW)) u_rom (
        .addr(rd_addr),
        .data(tx_data)
    );

endmodule

// File: rtl/desc_fetch_checker.sv
module desc_fetch_checker #(
    parameter int MEM_BYTES = 90,
    parameter int AW        = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [7:0]    tx_data,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          tx_last,
    input logic          done,
    input logic          req_err,
    input logic [AW-1:0] rd_addr
);

    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R9

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err); // R7

    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> !tx_valid && !done); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_ready && tx_last |=> done); // R10

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !tx_valid); // R10

    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> int'(rd_addr) < MEM_BYTES); // R11

endmodule

bind desc_fetch_unit desc_fetch_checker #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_last  (tx_last),
    .done     (done),
    .req_err  (req_err),
    .rd_addr  (rd_addr)
);

// File: tb/desc_fetch_unit_test.sv
`timescale 1ns/1ps
module desc_fetch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_type = '0;
    logic [7:0]  req_index = '0;
    logic [15:0] req_len = '0;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic        tx_last;
    logic        done;
    logic        req_err;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    desc_fetch_unit uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_type(req_type), .req_index(req_index), .req_len(req_len),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_last(tx_last), .done(done), .req_err(req_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // expected stored length; bad set for a request that must error (R7)
    function automatic int exp_stored(input int t, input int idx, output bit bad);
        bad = 1'b0;
        if (t == 1) return 18;
        if (t == 2) begin
            if (idx != 0) bad = 1'b1;
            return 32;
        end
        if (t == 3) begin
            if (idx == 0) return 4;
            if (idx <= 3) return 2 * idx + 8;
        end
        bad = 1'b1;
        return 0;
    endfunction

    function automatic int exp_start(input int t, input int idx);
        int o;
        if (t == 1) return 0;
        if (t == 2) return 18;
        if (idx == 0) return 50;
        o = 54;
        for (int j = 1; j < idx; j++) o += 2 * j + 8;
        return o;
    endfunction

    function automatic int exp_byte(input int a);
        int o;
        int base;
        int len;
        int r;
        if (a < 18) begin
            if (a == 0) return 18;
            if (a == 1) return 1;
        end else if (a < 50) begin
            o = a - 18;
            case (o)
                0: return 9;
                1: return 2;
                2: return 32;
                3: return 0;
                9: return 9;
                10: return 4;
                18, 25: return 7;
                19, 26: return 5;
                default: ;
            endcase
        end else begin
            o = a - 50;
            case (o)
                0: return 4;
                1: return 3;
                2: return 9;
                3: return 4;
                default: ;
            endcase
            base = 4;
            for (int k = 1; k <= 3; k++) begin
                len = 2 * k + 8;
                if (o >= base && o < base + len) begin
                    r = o - base;
                    if (r == 0) return len;
                    if (r == 1) return 3;
                    if (r % 2 == 1) return 0;
                    return 8'h40 + k;
                end
                base += len;
            end
        end
        return (a & 8'hFF) ^ 8'h5A;
    endfunction

    // ready_mode: 0 always ready, 1 random back-pressure
    task automatic run_req(input int t, input int idx, input int len, input int ready_mode, input string tag);
        bit   bad;
        int   stored;
        int   cnt;
        int   start;
        int   beats;
        int   bad_bytes;
        int   bad_last;
        int   first_act;
        int   first_exp;
        int   errs_seen;
        int   dones_seen;
        int   holds_bad;
        bit   prev_stall;
        logic [7:0] prev_data;
        bit   ended;
        stored = exp_stored(t, idx, bad);
        cnt    = bad ? 0 : ((len < stored) ? len : stored);
        start  = exp_start(t, idx);
        beats = 0; bad_bytes = 0; bad_last = 0; errs_seen = 0; dones_seen = 0;
        holds_bad = 0; prev_stall = 1'b0; prev_data = '0; ended = 1'b0;
        first_act = 0; first_exp = 0;
        @(negedge clk);
        req_valid = 1'b1; req_type = 8'(t); req_index = 8'(idx); req_len = 16'(len);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, {tag, " R10 busy after accept"}, int'(req_ready), 0);
        for (int cyc = 0; cyc < 600 && !ended; cyc++) begin
            tx_ready = (ready_mode == 0) ? 1'b1 : 1'($urandom_range(0, 2) != 0);
            #1;
            if (prev_stall && (!tx_valid || tx_data != prev_data)) holds_bad++;
            if (req_err) errs_seen++;
            if (done) dones_seen++;
            if (done || req_err) ended = 1'b1;
            if (tx_valid && tx_ready) begin
                if (int'(tx_data) != exp_byte(start + beats)) begin
                    if (bad_bytes == 0) begin
                        first_act = int'(tx_data);
                        first_exp = exp_byte(start + beats);
                    end
                    bad_bytes++;
                end
                if (tx_last != (beats == cnt - 1)) bad_last++;
                beats++;
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
            if (!ended) @(negedge clk);
        end
        if (!ended) check(1'b0, {tag, " watchdog"}, 0, 1);
        check(beats == cnt, {tag, " R6 byte count"}, beats, cnt);
        check(bad_bytes == 0, {tag, " R2 R3 R4 R5 byte values"}, first_act, first_exp);
        check(bad_last == 0, {tag, " R9 last flag"}, bad_last, 0);
        check(holds_bad == 0, {tag, " R9 hold under stall"}, holds_bad, 0);
        check(errs_seen == (bad ? 1 : 0), {tag, " R7 error pulse"}, errs_seen, bad ? 1 : 0);
        check(dones_seen == (bad ? 0 : 1), {tag, " R8 R10 done pulse"}, dones_seen, bad ? 0 : 1);
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check(req_ready && !tx_valid && !tx_last && !done && !req_err,
              "R1 reset idle", {tx_valid, done, req_err}, 0);
        check(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);

        run_req(1, 0, 64, 0, "R2 device full");
        run_req(1, 0, 5, 1, "R2 R6 device short");
        run_req(1, 7, 18, 1, "R2 device index ignored");
        run_req(2, 0, 255, 1, "R3 config full");
        run_req(2, 0, 9, 0, "R3 R6 config header only");
        run_req(2, 0, 32, 0, "R3 config exact");
        run_req(2, 1, 64, 0, "R7 config index 1");
        run_req(3, 0, 255, 0, "R4 language");
        run_req(3, 1, 255, 1, "R5 string 1");
        run_req(3, 2, 255, 1, "R5 string 2");
        run_req(3, 3, 255, 1, "R5 string 3");
        run_req(3, 3, 13, 0, "R5 R6 string 3 short");
        run_req(3, 4, 64, 0, "R7 invalid table entry");
        run_req(3, 5, 64, 0, "R7 beyond table");
        run_req(3, 200, 64, 0, "R7 far beyond table");
        run_req(0, 0, 64, 0, "R7 type 0");
        run_req(6, 0, 64, 0, "R7 type 6");
        run_req(1, 0, 0, 0, "R8 zero length device");
        run_req(3, 2, 0, 0, "R8 zero length string");
        run_req(2, 0, 1, 1, "R9 single beat");
        run_req(3, 3, 14, 1, "R11 last string end of memory");

        for (int n = 0; n < 80; n++) begin
            int t;
            int idx;
            int len;
            t   = $urandom_range(0, 4);
            idx = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 5);
            len = $urandom_range(0, 40);
            run_req(t, idx, len, 1, "random");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule